// File: doc/BRIEF.md
# Multichannel Packet Framing Checker

This block guards the input of a multichannel sample stream. Samples arrive under a ready/valid handshake with start-of-packet and end-of-packet markers and a 2-bit upstream error code. A packet is one sample per channel, with channels 0 to N-1 in order. The block numbers each accepted sample by channel and checks that the markers sit where the channel count says they must. Correctly framed samples are written into a small input FIFO. They leave through a second ready/valid port together with their channel index. A simple downstream sink takes them from there.

When the framing is broken, or when the upstream source raises a nonzero error code, the block reports a 2-bit code for one cycle and drops the offending sample. It then discards input until a new start-of-packet arrives. Only the framing controller resynchronises. Samples already in the FIFO are still delivered.

Top module: `pkt_frame_chk`

## Requirements
- R1: An input sample is taken only in a cycle where snk_valid and snk_ready are both high. snk_ready is low exactly while the FIFO holds DEPTH entries (default 4). A sample held valid while snk_ready is low has no effect.
- R2: A sample accepted with snk_sop high is channel 0. Each later accepted sample of the same packet takes the next channel index, and src_chan carries that index with the sample.
- R3: With NUM_CH channels, a packet whose snk_eop is high on exactly its channel NUM_CH-1 sample is delivered complete and in order. After it, the next packet starts from channel 0.
- R4: A sample without snk_sop, accepted while idle after a completed packet or after reset, is dropped and gives err_out = 01 in the cycle after acceptance.
- R5: Code 10 means a missing end-of-packet. It is raised when snk_sop arrives in the middle of a packet, or when the channel NUM_CH-1 sample lacks snk_eop. The sample is dropped.
- R6: Code 11 means an unexpected end-of-packet. It is raised when snk_eop arrives on a channel below NUM_CH-1. The sample is dropped.
- R7: An accepted sample carrying a nonzero snk_err is dropped, and that same code appears on err_out in the following cycle.
- R8: After any error, accepted samples without snk_sop are dropped silently, with err_out = 00. The next accepted snk_sop sample starts a new packet.
- R9: err_out shows each event's code for one cycle and otherwise reads 00.
- R10: src_valid is high whenever the FIFO is not empty, even while snk_valid is low. src_data and src_chan stay fixed while src_valid is high and src_ready is low.
- R11: rst_n is active low and synchronous. After reset the FIFO is empty, src_valid and err_out are 0, snk_ready is 1, and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| snk_valid | input | 1 | Input sample valid |
| snk_ready | output | 1 | Block can take an input sample |
| snk_data | input | DATA_W | Input sample |
| snk_sop | input | 1 | Start-of-packet marker |
| snk_eop | input | 1 | End-of-packet marker |
| snk_err | input | 2 | Upstream error code, 00 when clean |
| src_valid | output | 1 | Output sample valid |
| src_ready | input | 1 | Downstream can take a sample |
| src_data | output | DATA_W | Output sample |
| src_chan | output | CH_W | Channel index of the output sample |
| err_out | output | 2 | Error code: 01 no SOP, 10 no EOP, 11 bad EOP or other |

## Verification
The properties assume a well-behaved downstream port. src_ready may fall at any time, but the sink never reads src_data when src_valid is low. They also assume snk_err is meaningful only on accepted cycles. The bench drives every input on the falling clock edge and holds it until after the next rising edge. It changes src_ready only on falling edges, so each handshake is decided by values that are already stable. Illegal framing is only produced deliberately, one violation per directed scenario, so each expected error code can be attributed to a single sample.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BODY   = 2'd1,
    ST_RESYNC = 2'd2
  } frm_state_e;

  localparam logic [1:0] ERR_NONE    = 2'b00;
  localparam logic [1:0] ERR_NO_SOP  = 2'b01;
  localparam logic [1:0] ERR_NO_EOP  = 2'b10;
  localparam logic [1:0] ERR_BAD_EOP = 2'b11;

  // Framing verdict for a sample that may join a packet.
  // in_body : a packet is already open
  // at_last : the slot this sample would occupy is channel N-1
  function automatic logic [1:0] frame_code(input logic in_body,
                                            input logic sop,
                                            input logic eop,
                                            input logic at_last);
    logic [1:0] code;
    code = ERR_NONE;
    if (in_body && sop)       code = ERR_NO_EOP;
    else if (eop && !at_last) code = ERR_BAD_EOP;
    else if (!eop && at_last) code = ERR_NO_EOP;
    return code;
  endfunction

endpackage

// File: rtl/pfc_frame_fsm.sv
module pfc_frame_fsm
  import pfc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            sop,
  input  logic            eop,
  input  logic [1:0]      err_in,
  output logic            push,
  output logic [CH_W-1:0] push_chan,
  output logic [1:0]      err_code
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  frm_state_e      st_q, st_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic [CH_W-1:0] pos_c;
  logic [1:0]      code_c;
  logic            keep_c;

  always_comb begin
    st_d   = st_q;
    chan_d = chan_q;
    code_c = ERR_NONE;
    keep_c = 1'b0;
    pos_c  = (st_q == ST_BODY && !sop) ? chan_q : '0;
    if (acc) begin
      if (err_in != ERR_NONE) begin
        code_c = err_in;
        st_d   = ST_RESYNC;
        chan_d = '0;
      end else if (st_q != ST_BODY && !sop) begin
        if (st_q == ST_IDLE) code_c = ERR_NO_SOP;
        st_d   = ST_RESYNC;
        chan_d = '0;
      end else begin
        code_c = frame_code(st_q == ST_BODY, sop, eop, pos_c == LAST_CH);
        if (code_c != ERR_NONE) begin
          st_d   = ST_RESYNC;
          chan_d = '0;
        end else begin
          keep_c = 1'b1;
          if (pos_c == LAST_CH) begin
            st_d   = ST_IDLE;
            chan_d = '0;
          end else begin
            st_d   = ST_BODY;
            chan_d = pos_c + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      chan_q   <= '0;
      err_code <= ERR_NONE;
    end else begin
      st_q     <= st_d;
      chan_q   <= chan_d;
      err_code <= code_c;
    end
  end

  assign push      = keep_c;
  assign push_chan = pos_c;

endmodule

// File: rtl/pfc_fifo.sv
module pfc_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/pkt_frame_chk.sv
module pkt_frame_chk #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snk_valid,
  output logic              snk_ready,
  input  logic [DATA_W-1:0] snk_data,
  input  logic              snk_sop,
  input  logic              snk_eop,
  input  logic [1:0]        snk_err,
  output logic              src_valid,
  input  logic              src_ready,
  output logic [DATA_W-1:0] src_data,
  output logic [CH_W-1:0]   src_chan,
  output logic [1:0]        err_out
);

  localparam int ENT_W = CH_W + DATA_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  logic             acc_fire;
  logic             push_fire;
  logic             pop_fire;
  logic [CH_W-1:0]  push_chan;
  logic [CNT_W-1:0] fifo_count;
  logic             fifo_full, fifo_empty;
  logic [ENT_W-1:0] rd_ent;

  assign snk_ready = !fifo_full;
  assign acc_fire  = snk_valid && snk_ready;
  assign src_valid = !fifo_empty;
  assign pop_fire  = src_valid && src_ready;

  pfc_frame_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc_fire),
    .sop      (snk_sop),
    .eop      (snk_eop),
    .err_in   (snk_err),
    .push     (push_fire),
    .push_chan(push_chan),
    .err_code (err_out)
  );

  pfc_fifo #(.W(ENT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push_fire),
    .wdata({push_chan, snk_data}),
    .pop  (pop_fire),
    .rdata(rd_ent),
    .full (fifo_full),
    .empty(fifo_empty),
    .count(fifo_count)
  );

  assign src_chan = rd_ent[ENT_W-1:DATA_W];
  assign src_data = rd_ent[DATA_W-1:0];

endmodule

// File: rtl/pkt_frame_chk_sva.sv
module pkt_frame_chk_sva #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 4,
  parameter int CH_W   = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snk_sop,
  input logic              snk_eop,
  input logic [1:0]        snk_err,
  input logic              src_valid,
  input logic              src_ready,
  input logic [DATA_W-1:0] src_data,
  input logic [CH_W-1:0]   src_chan,
  input logic [1:0]        err_out,
  input logic              acc_fire,
  input logic              push_fire,
  input logic [CH_W-1:0]   push_chan,
  input logic [CNT_W-1:0]  fifo_count
);

  a_r1_push_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> acc_fire);

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  a_r2_sop_is_chan0: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && snk_sop) |-> (push_chan == '0));

  a_r3_eop_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && snk_eop) |-> (push_chan == CH_W'(NUM_CH - 1)));

  a_r7_upstream_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && snk_err != 2'b00) |=> (err_out == $past(snk_err)));

  a_r7_upstream_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && snk_err != 2'b00) |-> !push_fire);

  a_r9_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (err_out != 2'b00) |-> $past(acc_fire));

  a_r10_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready) |=> (src_valid && $stable(src_data) && $stable(src_chan)));

endmodule

bind pkt_frame_chk pkt_frame_chk_sva #(
  .DATA_W(DATA_W), .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CH_W(CH_W), .CNT_W(CNT_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .snk_sop   (snk_sop),
  .snk_eop   (snk_eop),
  .snk_err   (snk_err),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .src_data  (src_data),
  .src_chan  (src_chan),
  .err_out   (err_out),
  .acc_fire  (acc_fire),
  .push_fire (push_fire),
  .push_chan (push_chan),
  .fifo_count(fifo_count)
);

// File: tb/pkt_frame_chk_tb.sv
module pkt_frame_chk_tb;

  localparam int DW = 16;
  localparam int NC = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          snk_valid = 1'b0;
  logic          snk_ready;
  logic [DW-1:0] snk_data = '0;
  logic          snk_sop = 1'b0;
  logic          snk_eop = 1'b0;
  logic [1:0]    snk_err = 2'b00;
  logic          src_valid;
  logic          src_ready = 1'b1;
  logic [DW-1:0] src_data;
  logic [CW-1:0] src_chan;
  logic [1:0]    err_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [CW+DW-1:0] exp_q [64];
  logic [CW+DW-1:0] rx_q  [64];
  int n_exp = 0;
  int n_rx  = 0;

  always #4 clk = ~clk;

  pkt_frame_chk #(.DATA_W(DW), .NUM_CH(NC), .DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .snk_sop(snk_sop), .snk_eop(snk_eop), .snk_err(snk_err),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .src_chan(src_chan), .err_out(err_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // sink monitor: records transfers between edges
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && src_valid && src_ready && n_rx < 64) begin
      rx_q[n_rx] = {src_chan, src_data};
      n_rx++;
    end
  end

  // one sample: called at a falling edge, returns at a falling edge
  task automatic beat(input logic [DW-1:0] d, input logic sop, input logic eop,
                      input logic [1:0] e, input logic [1:0] exp_err,
                      input bit keep, input int chan, input string tag);
    snk_data = d; snk_sop = sop; snk_eop = eop; snk_err = e; snk_valid = 1'b1;
    while (!snk_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(err_out == exp_err, tag, err_out, exp_err);
    snk_valid = 1'b0; snk_sop = 1'b0; snk_eop = 1'b0; snk_err = 2'b00;
    if (keep) begin
      exp_q[n_exp] = {CW'(chan), d};
      n_exp++;
    end
  endtask

  task automatic good_packet(input logic [DW-1:0] base, input string tag);
    for (int c = 0; c < NC; c++)
      beat(base + DW'(c), c == 0, c == NC - 1, 2'b00, 2'b00, 1, c, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(snk_ready == 1'b1, "R11 snk_ready", snk_ready, 1);
    check(src_valid == 1'b0, "R11 src_valid", src_valid, 0);
    check(err_out == 2'b00, "R11 err_out", err_out, 0);
  endtask

  task automatic t_good();
    good_packet(16'h1000, "R2 good packet");
    good_packet(16'h1100, "R3 back-to-back packet");
  endtask

  task automatic t_missing_sop();
    beat(16'h2000, 0, 0, 2'b00, 2'b01, 0, 0, "R4 missing sop code");
    beat(16'h2001, 0, 0, 2'b00, 2'b00, 0, 0, "R8 silent drop");
    good_packet(16'h2100, "R8 restart on sop");
  endtask

  task automatic t_missing_eop();
    beat(16'h3000, 1, 0, 2'b00, 2'b00, 1, 0, "R5 open");
    beat(16'h3001, 0, 0, 2'b00, 2'b00, 1, 1, "R5 body");
    beat(16'h3002, 1, 0, 2'b00, 2'b10, 0, 0, "R5 sop mid-packet");
    beat(16'h3003, 0, 0, 2'b00, 2'b00, 0, 0, "R8 drop after error");
    for (int c = 0; c < NC; c++)
      beat(16'h3100 + DW'(c), c == 0, 0, 2'b00, (c == NC - 1) ? 2'b10 : 2'b00,
           c != NC - 1, c, "R5 last channel without eop");
    good_packet(16'h3200, "R8 recover");
  endtask

  task automatic t_bad_eop();
    beat(16'h4000, 1, 0, 2'b00, 2'b00, 1, 0, "R6 open");
    beat(16'h4001, 0, 1, 2'b00, 2'b11, 0, 0, "R6 early eop");
    beat(16'h4002, 1, 1, 2'b00, 2'b11, 0, 0, "R6 eop on channel 0");
    good_packet(16'h4100, "R6 recover");
  endtask

  task automatic t_upstream();
    beat(16'h5000, 1, 0, 2'b00, 2'b00, 1, 0, "R7 open");
    beat(16'h5001, 0, 0, 2'b10, 2'b10, 0, 0, "R7 forward 10");
    beat(16'h5002, 0, 0, 2'b00, 2'b00, 0, 0, "R8 drop after upstream error");
    beat(16'h5003, 1, 0, 2'b01, 2'b01, 0, 0, "R7 forward 01 on sop");
    good_packet(16'h5100, "R7 recover");
    @(negedge clk);
    check(err_out == 2'b00, "R9 code lasts one cycle", err_out, 0);
  endtask

  task automatic t_backpressure();
    logic [CW+DW-1:0] head;
    repeat (10) @(negedge clk);
    src_ready = 1'b0;
    good_packet(16'h6000, "R1 fill");
    check(snk_ready == 1'b0, "R1 ready low when full", snk_ready, 0);
    check(src_valid == 1'b1, "R10 valid while stalled", src_valid, 1);
    head = {src_chan, src_data};
    check(head == {2'd0, 16'h6000}, "R10 head entry", head, {2'd0, 16'h6000});
    snk_data = 16'h6FFF; snk_sop = 1'b1; snk_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(err_out == 2'b00, "R1 unaccepted sample ignored", err_out, 0);
    check({src_chan, src_data} == head, "R10 stable while stalled", src_data, head[DW-1:0]);
    snk_valid = 1'b0; snk_sop = 1'b0;
    @(negedge clk);
    src_ready = 1'b1;
    repeat (6) @(negedge clk);
    check(src_valid == 1'b0, "R10 drains with snk_valid low", src_valid, 0);
    good_packet(16'h6100, "R1 channel count unaffected by stalled sample");
  endtask

  task automatic t_compare();
    for (int i = 0; i < 50 && n_rx < n_exp; i++) @(negedge clk);
    check(n_rx == n_exp, "R3 delivered count", n_rx, n_exp);
    for (int i = 0; i < n_exp && i < n_rx; i++)
      check(rx_q[i] == exp_q[i], "R2 R3 delivered sample and channel", rx_q[i], exp_q[i]);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_good();
    t_missing_sop();
    t_missing_eop();
    t_bad_eop();
    t_upstream();
    t_backpressure();
    t_compare();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

endmodule